// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block sits behind a sync slicer and a line-period tracker. It takes the sliced, active-low composite sync as a clocked bit stream, plus a one-cycle line-start strobe and the measured line length in clocks from the tracker. From these it finds the vertical sync interval and drives an active-low vertical sync pulse. It also drives a field indicator that is high for the first (odd) field and low for the second (even) field. A vertical-interval flag lets a downstream horizontal pulse generator hold off during the interval.

The block treats any sync-low pulse that lasts at least 3/8 of the line length as a broad vertical pulse. On standard signals the rising edge that ends the first broad pulse starts the vertical sync output. On unserrated signals the vertical interval is one long low stretch, and the output then starts once that stretch has lasted a full line length. The output pulse is three line starts long. The field identity comes from where the first broad pulse falls within the line: near a line boundary gives field 1, near mid-line gives field 2. Two fields in a row with the same start phase mean the source is progressive, and the field indicator is then held high.

Top module: `vsync_field_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, vsync_n is 1, field_odd is 1 and vert_active is 0.
- R2: Sync-low pulses shorter than 3/8 of line_len never raise vert_active and never pull vsync_n low.
- R3: With the default one-stage input register, vert_active rises on the (T+2)-th rising clock edge after csync_n goes low, where T = line_len/4 + line_len/8 (integer shifts). It is still low after the (T+1)-th edge.
- R4: On serrated input, vsync_n falls on the second rising edge after csync_n rises at the end of the first broad pulse. Later broad pulses in the same interval cause no further falling edge.
- R5: vsync_n stays low until the third line_start after its falling edge and rises right after that third line_start.
- R6: On unserrated input, vsync_n falls on the (line_len+2)-th rising edge after csync_n goes low.
- R7: After vsync_n falls, no new vertical interval can start until HOLD_LINES line starts have passed. A broad pulse inside that window leaves vert_active low and vsync_n high.
- R8: field_odd changes only in the cycle in which vsync_n falls.
- R9: If the first broad pulse starts within 3/32 of line_len of a line boundary, the new field is field 1 (field_odd = 1). If it starts outside that window, for example at mid-line, the new field is field 2 (field_odd = 0). This holds whenever the start phase differs from that of the previous field.
- R10: If two consecutive vertical intervals start at the same phase class, the signal is progressive and field_odd is set to 1.
- R11: With csync_n held high and line starts running, vsync_n stays high, vert_active stays low and field_odd keeps its last value.
- R12: vert_active is 1 whenever vsync_n is 0, and returns to 0 when vsync_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| line_start | input | 1 | One-cycle strobe at each line boundary from the line tracker |
| line_len | input | LEN_W | Measured line period in clocks |
| vsync_n | output | 1 | Active-low vertical sync pulse |
| field_odd | output | 1 | 1 for field 1 or progressive, 0 for field 2 |
| vert_active | output | 1 | High from broad-pulse detection to the end of the vertical pulse |

## Verification
The bench builds the block with its default parameters: LEN_W = 12, VS_LINES = 3, HOLD_LINES = 6 and the input register enabled. It drives a line length of 200 clocks. With 200-clock lines, the broad threshold is 75 clocks and the boundary window is 19 clocks. Six-line hold-off windows and eight-line gaps between fields are therefore short enough to run five vertical intervals of different shape in a single run. These intervals are serrated and unserrated, start at a boundary or at mid-line, and come in alternating and repeated phase. The run also covers the lockout, the idle and the short-pulse cases, and every edge is checked on its exact clock.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

   typedef enum logic {
      CLS_EDGE = 1'b0,
      CLS_MID  = 1'b1
   } vstart_cls_t;

   // Window around the line boundary: len/8 - len/32 (about 9.4 percent).
   function automatic vstart_cls_t classify_start(input logic [31:0] ph,
                                                  input logic [31:0] len);
      logic [31:0] tol;
      tol = (len >> 3) - (len >> 5);
      if ((ph < tol) || (ph >= len - tol))
         return CLS_EDGE;
      return CLS_MID;
   endfunction

endpackage

// File: rtl/vsf_pulse_meas.sv
module vsf_pulse_meas #(
   parameter int LEN_W  = 12,
   parameter bit IN_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csync_n,
   input  logic             line_start,
   input  logic [LEN_W-1:0] line_len,
   output logic             broad_hit,
   output logic             ser_hit,
   output logic             long_hit,
   output logic [LEN_W-1:0] fall_phase
);

   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   logic             cs;
   logic             cs_d;
   logic [LEN_W-1:0] phase;
   logic [LEN_W-1:0] low_cnt;
   logic [LEN_W-1:0] thr;

   generate
      if (IN_REG) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cs <= 1'b1;
            else        cs <= csync_n;
         end
      end else begin : g_in_pass
         assign cs = csync_n;
      end
   endgenerate

   // Broad threshold: 3/8 of the line period.
   assign thr = (line_len >> 2) + (line_len >> 3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d       <= 1'b1;
         phase      <= '0;
         low_cnt    <= '0;
         fall_phase <= '0;
      end else begin
         cs_d <= cs;
         if (line_start)           phase <= '0;
         else if (phase != CNT_MAX) phase <= phase + 1'b1;
         if (!cs) begin
            if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
         end else begin
            low_cnt <= '0;
         end
         if (!cs && cs_d) fall_phase <= phase;
      end
   end

   assign broad_hit = !cs && (thr != '0) && (low_cnt == thr);
   assign ser_hit   = cs && !cs_d && (thr != '0) && (low_cnt >= thr);
   assign long_hit  = !cs && (low_cnt == line_len);

endmodule

// File: rtl/vsf_vs_gen.sv
module vsf_vs_gen #(
   parameter int VS_LINES   = 3,
   parameter int HOLD_LINES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic broad_hit,
   input  logic ser_hit,
   input  logic long_hit,
   output logic arm,
   output logic fire,
   output logic vsync_n,
   output logic vert_active
);

   localparam int               LC_W      = $clog2(HOLD_LINES + 1);
   localparam logic [LC_W-1:0]  HOLD_V    = LC_W'(HOLD_LINES);
   localparam logic [LC_W-1:0]  LOW_FLOOR = LC_W'(HOLD_LINES - VS_LINES);

   logic            armed;
   logic [LC_W-1:0] lcnt;

   assign arm  = broad_hit && !armed && (lcnt == '0);
   assign fire = armed && (ser_hit || long_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         lcnt  <= '0;
      end else begin
         if (arm)       armed <= 1'b1;
         else if (fire) armed <= 1'b0;
         if (fire)                            lcnt <= HOLD_V;
         else if (line_start && lcnt != '0)   lcnt <= lcnt - 1'b1;
      end
   end

   assign vsync_n     = !(lcnt > LOW_FLOOR);
   assign vert_active = armed || !vsync_n;

endmodule

// File: rtl/vsf_field_track.sv
module vsf_field_track
   import vsf_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             fire,
   input  logic [LEN_W-1:0] fall_phase,
   input  logic [LEN_W-1:0] line_len,
   output logic             field_odd
);

   vstart_cls_t cls_pend;
   vstart_cls_t prev_cls;
   logic        have_prev;
   logic        progressive;

   assign progressive = have_prev && (cls_pend == prev_cls);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_pend  <= CLS_EDGE;
         prev_cls  <= CLS_EDGE;
         have_prev <= 1'b0;
         field_odd <= 1'b1;
      end else begin
         if (arm) cls_pend <= classify_start(32'(fall_phase), 32'(line_len));
         if (fire) begin
            field_odd <= progressive || (cls_pend == CLS_EDGE);
            prev_cls  <= cls_pend;
            have_prev <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/vsync_field_detect.sv
module vsync_field_detect #(
   parameter int LEN_W      = 12,
   parameter int VS_LINES   = 3,
   parameter int HOLD_LINES = 6,
   parameter bit IN_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csync_n,
   input  logic             line_start,
   input  logic [LEN_W-1:0] line_len,
   output logic             vsync_n,
   output logic             field_odd,
   output logic             vert_active
);

   generate
      if (LEN_W < 6) begin : g_bad_len
         $error("LEN_W must be at least 6");
      end
      if (VS_LINES < 1) begin : g_bad_vs
         $error("VS_LINES must be at least 1");
      end
      if (HOLD_LINES <= VS_LINES) begin : g_bad_hold
         $error("HOLD_LINES must exceed VS_LINES");
      end
   endgenerate

   logic             broad_hit;
   logic             ser_hit;
   logic             long_hit;
   logic             arm;
   logic             fire;
   logic [LEN_W-1:0] fall_phase;

   vsf_pulse_meas #(
      .LEN_W  (LEN_W),
      .IN_REG (IN_REG)
   ) i_meas (
      .clk        (clk),
      .rst_n      (rst_n),
      .csync_n    (csync_n),
      .line_start (line_start),
      .line_len   (line_len),
      .broad_hit  (broad_hit),
      .ser_hit    (ser_hit),
      .long_hit   (long_hit),
      .fall_phase (fall_phase)
   );

   vsf_vs_gen #(
      .VS_LINES   (VS_LINES),
      .HOLD_LINES (HOLD_LINES)
   ) i_vs (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_start  (line_start),
      .broad_hit   (broad_hit),
      .ser_hit     (ser_hit),
      .long_hit    (long_hit),
      .arm         (arm),
      .fire        (fire),
      .vsync_n     (vsync_n),
      .vert_active (vert_active)
   );

   vsf_field_track #(
      .LEN_W (LEN_W)
   ) i_field (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .fire       (fire),
      .fall_phase (fall_phase),
      .line_len   (line_len),
      .field_odd  (field_odd)
   );

endmodule

// File: rtl/vsf_checker.sv
module vsf_checker #(
   parameter int VS_LINES = 3
) (
   input logic clk,
   input logic rst_n,
   input logic line_start,
   input logic vsync_n,
   input logic field_odd,
   input logic vert_active
);

   localparam int              CW     = $clog2(VS_LINES + 1) + 1;
   localparam logic [CW-1:0]   LAST_L = CW'(VS_LINES - 1);

   logic [CW-1:0] vs_lines;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vs_lines <= '0;
      else if (vsync_n)    vs_lines <= '0;
      else if (line_start) vs_lines <= vs_lines + 1'b1;
   end

   // R1
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (vsync_n && field_odd && !vert_active));

   // R4: a vertical pulse only follows an armed interval
   p_fall_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vsync_n) |-> $past(vert_active));

   // R5: pulse ends at the VS_LINES-th line start
   p_vs_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vsync_n && line_start && vs_lines == LAST_L) |=> vsync_n);

   p_vs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vsync_n && !(line_start && vs_lines == LAST_L)) |=> !vsync_n);

   // R8
   p_odd_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (field_odd != $past(field_odd)) |-> $fell(vsync_n));

   // R12
   p_vs_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> vert_active);

endmodule

bind vsync_field_detect vsf_checker #(
   .VS_LINES (VS_LINES)
) i_vsf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_start  (line_start),
   .vsync_n     (vsync_n),
   .field_odd   (field_odd),
   .vert_active (vert_active)
);

// File: tb/test_vsync_field_detect.sv
module test_vsync_field_detect;

   localparam int L     = 200;
   localparam int THR   = (L >> 2) + (L >> 3);
   localparam int BROAD = 85;
   localparam int GAP   = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csync_n = 1'b1;
   logic        line_start = 1'b0;
   logic [11:0] line_len = 12'(L);
   logic        vsync_n;
   logic        field_odd;
   logic        vert_active;

   int   ph = 0;
   int   falls = 0;
   logic vs_prev = 1'b1;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   vsync_field_detect i_vsync_field_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .csync_n     (csync_n),
      .line_start  (line_start),
      .line_len    (line_len),
      .vsync_n     (vsync_n),
      .field_odd   (field_odd),
      .vert_active (vert_active)
   );

   always @(negedge clk) begin
      ph         <= (ph == L - 1) ? 0 : ph + 1;
      line_start <= (ph == L - 1);
      if (rst_n && vs_prev && !vsync_n) falls <= falls + 1;
      vs_prev <= vsync_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ph(input int p);
      @(negedge clk);
      while (ph != p) @(negedge clk);
   endtask

   task automatic send_vert(input int obs, input bit serr);
      wait_ph(obs);
      if (serr) begin
         repeat (6) begin
            csync_n = 1'b0; idle(BROAD);
            csync_n = 1'b1; idle(GAP);
         end
      end else begin
         csync_n = 1'b0; idle(L + 20);
         csync_n = 1'b1;
      end
      idle(L * 8);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; csync_n = 1'b1;
      idle(3);
      chk(vsync_n == 1'b1, "R1", "vsync_n in reset", vsync_n, 1);
      chk(field_odd == 1'b1, "R1", "field_odd in reset", field_odd, 1);
      chk(vert_active == 1'b0, "R1", "vert_active in reset", vert_active, 0);
      rst_n = 1'b1;
      idle(1);
      chk(vsync_n && field_odd && !vert_active, "R1", "state after release",
          {vsync_n, field_odd, vert_active}, 3'b110);
   endtask

   task automatic t_short_pulses;
      int f0;
      f0 = falls;
      repeat (4) begin
         wait_ph(L - 1);
         csync_n = 1'b0; idle(GAP);
         chk(vert_active == 1'b0, "R2", "vert_active in short pulse", vert_active, 0);
         csync_n = 1'b1;
      end
      idle(5);
      chk(vsync_n == 1'b1, "R2", "vsync_n after short pulses", vsync_n, 1);
      chk(falls == f0, "R2", "vsync falls", falls - f0, 0);
   endtask

   task automatic t_first_field;
      wait_ph(L - 1);
      csync_n = 1'b0;
      idle(THR + 1);
      chk(vert_active == 1'b0, "R3", "vert_active before threshold", vert_active, 0);
      idle(1);
      chk(vert_active == 1'b1, "R3", "vert_active at threshold", vert_active, 1);
      idle(BROAD - THR - 2);
      csync_n = 1'b1;
      idle(1);
      chk(vsync_n == 1'b1, "R4", "vsync_n one edge after serration", vsync_n, 1);
      idle(1);
      chk(vsync_n == 1'b0, "R4", "vsync_n two edges after serration", vsync_n, 0);
      chk(field_odd == 1'b1, "R9", "field_odd boundary start", field_odd, 1);
      chk(vert_active == 1'b1, "R12", "vert_active during pulse", vert_active, 1);
      wait_ph(L - 1); idle(1);
      chk(vsync_n == 1'b0, "R5", "vsync_n after 1st line start", vsync_n, 0);
      wait_ph(L - 1); idle(1);
      chk(vsync_n == 1'b0, "R5", "vsync_n after 2nd line start", vsync_n, 0);
      wait_ph(L - 1); idle(1);
      chk(vsync_n == 1'b1, "R5", "vsync_n after 3rd line start", vsync_n, 1);
      chk(vert_active == 1'b0, "R12", "vert_active after pulse", vert_active, 0);
   endtask

   task automatic t_lockout;
      wait_ph(L - 1);
      csync_n = 1'b0; idle(90);
      csync_n = 1'b1; idle(5);
      chk(vert_active == 1'b0, "R7", "vert_active in hold-off", vert_active, 0);
      chk(vsync_n == 1'b1, "R7", "vsync_n in hold-off", vsync_n, 1);
      idle(L * 8);
   endtask

   task automatic t_second_field;
      int f0;
      f0 = falls;
      wait_ph(L / 2 - 1);
      csync_n = 1'b0; idle(BROAD);
      chk(field_odd == 1'b1, "R8", "field_odd before fall", field_odd, 1);
      csync_n = 1'b1; idle(1);
      chk(field_odd == 1'b1, "R8", "field_odd one edge after serration", field_odd, 1);
      idle(1);
      chk(vsync_n == 1'b0, "R4", "vsync_n mid-line interval", vsync_n, 0);
      chk(field_odd == 1'b0, "R9", "field_odd mid-line start", field_odd, 0);
      idle(GAP - 2);
      repeat (5) begin
         csync_n = 1'b0; idle(BROAD);
         csync_n = 1'b1; idle(GAP);
      end
      idle(L * 8);
      chk(falls - f0 == 1, "R4", "falls per serrated interval", falls - f0, 1);
   endtask

   task automatic t_idle;
      int f0;
      f0 = falls;
      csync_n = 1'b1;
      repeat (5) begin
         wait_ph(L / 2);
         chk(vsync_n == 1'b1, "R11", "vsync_n idle", vsync_n, 1);
      end
      chk(field_odd == 1'b0, "R11", "field_odd kept", field_odd, 0);
      chk(vert_active == 1'b0, "R11", "vert_active idle", vert_active, 0);
      chk(falls == f0, "R11", "falls idle", falls - f0, 0);
   endtask

   task automatic t_third_field;
      send_vert(L - 1, 1'b1);
      chk(field_odd == 1'b1, "R9", "field_odd boundary after mid", field_odd, 1);
   endtask

   task automatic t_unserrated;
      wait_ph(L / 2 - 1);
      csync_n = 1'b0;
      idle(L + 1);
      chk(vsync_n == 1'b1, "R6", "vsync_n before default", vsync_n, 1);
      idle(1);
      chk(vsync_n == 1'b0, "R6", "vsync_n default pulse", vsync_n, 0);
      chk(field_odd == 1'b0, "R9", "field_odd unserrated mid", field_odd, 0);
      idle(19);
      csync_n = 1'b1;
      idle(L * 8);
   endtask

   task automatic t_progressive;
      send_vert(L / 2 - 1, 1'b1);
      chk(field_odd == 1'b1, "R10", "field_odd repeated phase", field_odd, 1);
   endtask

   initial begin
      t_reset();
      t_short_pulses();
      t_first_field();
      t_lockout();
      t_second_field();
      t_idle();
      t_third_field();
      t_unserrated();
      t_progressive();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule